// File: doc/BRIEF.md
# Fixed-Point Integer Narrowing Unit

This unit shortens a fixed-point word by dropping integer bits from its top. The binary point does not move and the fractional bits are never touched. The input is `IN_W` bits wide and the result keeps its low `OUT_W` bits. If the value still fits in the narrower word, those low bits are passed through as they are.

If the value does not fit, a per-sample mode code chooses what the result becomes:
- a clamped extreme;
- zero;
- a clamp that is symmetric about zero;
- a wrap-around that can force a group of top bits;
- a wrap-around in sign-magnitude style.

The wrap-style modes take a saturated-bit count as an input, clamped to the output width. A select input says whether the word is two's complement or unsigned.

Each accepted sample gives a registered result one cycle later, together with a valid flag and that sample's overflow flag. A separate flag records that an overflow has happened at any time since reset.

Top module: `fxo_narrow`

## Requirements
- R1: The removed bits are `din_i[IN_W-1:OUT_W]`. A signed sample overflows when any removed bit differs from `din_i[OUT_W-1]`. An unsigned sample overflows when any removed bit is 1. `ovf_o` reports this for the sample shown on `dout_o`.
- R2: When a sample does not overflow, `dout_o` equals `din_i[OUT_W-1:0]` for every mode code and every saturated-bit count.
- R3: Mode code 0 (clamp). A signed overflow gives the original sign `din_i[IN_W-1]` in the result MSB and its inverse in every other bit. An unsigned overflow gives all ones.
- R4: Mode code 1 (zero). Any overflow, signed or unsigned, gives all zeros.
- R5: Mode code 2 (symmetric clamp). It acts as mode 0 but forces result bit 0 to 1, so a negative clamp becomes `100..01`. Unsigned overflow gives all ones.
- R6: Mode code 3, signed wrap, with effective count n:
  - n=0 copies the low bits.
  - n=1 puts the original sign in the MSB and copies the rest.
  - n>1 also sets the n-1 bits below the MSB to the inverted sign and copies the rest.
- R7: Mode code 4, signed sign-magnitude wrap. Let s be the new MSB and r the original `din_i[OUT_W-1]`.
  - n=0: s is `din_i[OUT_W]` and every lower bit is XORed with r and s.
  - n=1: s is the original sign, with the same XOR rule.
  - n>1: s is the original sign and the n-1 bits below it are the inverted sign. Each remaining bit is XORed with `din_i[OUT_W-n]` and the inverted sign.
- R8: For unsigned overflow, mode codes 3 and 4 both set the top n result bits to 1 and copy the rest.
- R9: The effective count n is `nbits_i` limited to `OUT_W`.
- R10: Mode codes 5, 6 and 7 behave as code 0.
- R11: A sample with `valid_i` high appears on `dout_o`/`ovf_o` one cycle later with `valid_o` high. With `valid_i` low, `dout_o` and `ovf_o` hold and `valid_o` is low.
- R12: After reset, all outputs are 0. `ovf_seen_o` rises with the first overflowing sample and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Sample strobe |
| signed_i | input | 1 | 1 = two's complement, 0 = unsigned |
| mode_i | input | 3 | Overflow mode code |
| nbits_i | input | NB_W (3) | Saturated-bit count before clamping |
| din_i | input | IN_W (12) | Wide input word |
| valid_o | output | 1 | Result valid |
| dout_o | output | OUT_W (6) | Narrowed word |
| ovf_o | output | 1 | Overflow of the shown sample |
| ovf_seen_o | output | 1 | Sticky overflow since reset |

## Verification
The per-sample overflow flag and the sticky flag are updated by the same sample, and they can disagree on the next one. The bench sends an overflowing sample followed immediately by a sample that fits. It then requires `ovf_o` to fall while `ovf_seen_o` stays high and `dout_o` shows the untouched low bits. It also changes every input while `valid_i` is low, so that holding the result and taking a new sample are judged in consecutive cycles.

// File: rtl/fxo_pkg.sv
package fxo_pkg;

  typedef enum logic [2:0] {
    OVF_SAT    = 3'd0,
    OVF_ZERO   = 3'd1,
    OVF_SYM    = 3'd2,
    OVF_WRAP   = 3'd3,
    OVF_SMWRAP = 3'd4
  } ovf_mode_e;

  function automatic ovf_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd1:    decode_mode = OVF_ZERO;
      3'd2:    decode_mode = OVF_SYM;
      3'd3:    decode_mode = OVF_WRAP;
      3'd4:    decode_mode = OVF_SMWRAP;
      default: decode_mode = OVF_SAT;
    endcase
  endfunction

endpackage

// File: rtl/fxo_ovf_detect.sv
module fxo_ovf_detect #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 6
) (
  input  logic [IN_W-1:0] din,
  input  logic            is_signed,
  output logic            ovf
);
  localparam int REM_W = IN_W - OUT_W;

  logic [REM_W-1:0] removed;
  logic             sign_ext_bad;
  logic             any_set;

  always_comb begin
    removed      = din[IN_W-1:OUT_W];
    any_set      = |removed;
    sign_ext_bad = (removed != {REM_W{din[OUT_W-1]}});
    ovf          = is_signed ? sign_ext_bad : any_set;
  end

endmodule

// File: rtl/fxo_signed_map.sv
module fxo_signed_map
  import fxo_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 6,
  parameter int NB_W  = 3
) (
  input  logic [IN_W-1:0]  din,
  input  ovf_mode_e        mode,
  input  logic [NB_W-1:0]  n_eff,
  output logic [OUT_W-1:0] dout
);
  logic             sd;
  logic             ld;
  logic             sro;
  logic             lno;
  logic             top;
  logic [OUT_W-1:0] sat_v;
  int               n;

  always_comb begin
    sd    = din[IN_W-1];
    ld    = din[OUT_W];
    sro   = din[OUT_W-1];
    n     = int'(n_eff);
    lno   = 1'b0;
    for (int j = 0; j < OUT_W; j++) begin
      if (j == OUT_W - n) lno = din[j];
    end
    top   = (n == 0) ? ld : sd;
    sat_v = {sd, {(OUT_W-1){~sd}}};
    dout  = sat_v;
    case (mode)
      OVF_ZERO: dout = '0;
      OVF_SYM: begin
        dout    = sat_v;
        dout[0] = 1'b1;
      end
      OVF_WRAP: begin
        for (int i = 0; i < OUT_W; i++) begin
          if (n == 0)                dout[i] = din[i];
          else if (OUT_W-1-i == 0)   dout[i] = sd;
          else if (OUT_W-1-i < n)    dout[i] = ~sd;
          else                       dout[i] = din[i];
        end
      end
      OVF_SMWRAP: begin
        for (int i = 0; i < OUT_W; i++) begin
          if (OUT_W-1-i == 0)        dout[i] = top;
          else if (n <= 1)           dout[i] = din[i] ^ sro ^ top;
          else if (OUT_W-1-i < n)    dout[i] = ~sd;
          else                       dout[i] = din[i] ^ lno ^ ~sd;
        end
      end
      default: dout = sat_v;
    endcase
  end

endmodule

// File: rtl/fxo_unsigned_map.sv
module fxo_unsigned_map
  import fxo_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 6,
  parameter int NB_W  = 3
) (
  input  logic [IN_W-1:0]  din,
  input  ovf_mode_e        mode,
  input  logic [NB_W-1:0]  n_eff,
  output logic [OUT_W-1:0] dout
);
  int n;

  always_comb begin
    n    = int'(n_eff);
    dout = '1;
    case (mode)
      OVF_ZERO: dout = '0;
      OVF_WRAP, OVF_SMWRAP: begin
        for (int i = 0; i < OUT_W; i++) begin
          dout[i] = (OUT_W-1-i < n) ? 1'b1 : din[i];
        end
      end
      default: dout = '1;
    endcase
  end

endmodule

// File: rtl/fxo_narrow.sv
module fxo_narrow
  import fxo_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 6,
  parameter int NB_W  = $clog2(OUT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             signed_i,
  input  logic [2:0]       mode_i,
  input  logic [NB_W-1:0]  nbits_i,
  input  logic [IN_W-1:0]  din_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] dout_o,
  output logic             ovf_o,
  output logic             ovf_seen_o
);
  localparam logic [NB_W-1:0] N_MAX = NB_W'(OUT_W);

  logic             rst_s1_q, rst_q_n;
  ovf_mode_e        mode_c;
  logic [NB_W-1:0]  n_eff;
  logic             ovf_c;
  logic [OUT_W-1:0] smap, umap, res_c;

  logic             vld_d, vld_q;
  logic [OUT_W-1:0] res_d, res_q;
  logic             ovf_d, ovf_q;
  logic             seen_d, seen_q;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_q_n  <= rst_s1_q;
    end
  end

  always_comb begin
    mode_c = decode_mode(mode_i);
    n_eff  = (nbits_i > N_MAX) ? N_MAX : nbits_i;
  end

  fxo_ovf_detect #(.IN_W(IN_W), .OUT_W(OUT_W)) det_i (
    .din(din_i), .is_signed(signed_i), .ovf(ovf_c)
  );

  fxo_signed_map #(.IN_W(IN_W), .OUT_W(OUT_W), .NB_W(NB_W)) smap_i (
    .din(din_i), .mode(mode_c), .n_eff(n_eff), .dout(smap)
  );

  fxo_unsigned_map #(.IN_W(IN_W), .OUT_W(OUT_W), .NB_W(NB_W)) umap_i (
    .din(din_i), .mode(mode_c), .n_eff(n_eff), .dout(umap)
  );

  always_comb begin
    res_c  = ovf_c ? (signed_i ? smap : umap) : din_i[OUT_W-1:0];
    vld_d  = valid_i;
    res_d  = valid_i ? res_c : res_q;
    ovf_d  = valid_i ? ovf_c : ovf_q;
    seen_d = seen_q | (valid_i & ovf_c);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q  <= 1'b0;
      res_q  <= '0;
      ovf_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      res_q  <= res_d;
      ovf_q  <= ovf_d;
      seen_q <= seen_d;
    end
  end

  assign valid_o    = vld_q;
  assign dout_o     = res_q;
  assign ovf_o      = ovf_q;
  assign ovf_seen_o = seen_q;

  // R11
  valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    valid_i |=> valid_o);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !valid_i |=> ($stable(dout_o) && $stable(ovf_o) && !valid_o));

  // R12
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ovf_seen_o |=> ovf_seen_o);

  // R12
  seen_cover_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ovf_o |-> ovf_seen_o);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_o && !ovf_o) |-> (dout_o == $past(din_i[OUT_W-1:0])));

  // R4
  zero_mode_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_o && ovf_o && ($past(mode_i) == 3'd1)) |-> (dout_o == '0));

endmodule

// File: tb/fxo_narrow_tb.sv
`timescale 1ns/1ps
module fxo_narrow_tb_top;
  localparam int IN_W  = 12;
  localparam int OUT_W = 6;
  localparam int NB_W  = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             valid_i;
  logic             signed_i;
  logic [2:0]       mode_i;
  logic [NB_W-1:0]  nbits_i;
  logic [IN_W-1:0]  din_i;
  logic             valid_o;
  logic [OUT_W-1:0] dout_o;
  logic             ovf_o;
  logic             ovf_seen_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fxo_narrow #(.IN_W(IN_W), .OUT_W(OUT_W), .NB_W(NB_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .signed_i(signed_i),
    .mode_i(mode_i), .nbits_i(nbits_i), .din_i(din_i),
    .valid_o(valid_o), .dout_o(dout_o), .ovf_o(ovf_o), .ovf_seen_o(ovf_seen_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // drive one sample; results are sampled at the next falling edge
  task automatic send(input logic [IN_W-1:0] d, input logic sg,
                      input logic [2:0] m, input logic [NB_W-1:0] nb);
    @(negedge clk);
    din_i = d; signed_i = sg; mode_i = m; nbits_i = nb; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12 reset valid", valid_o, 0);
    chk("R12 reset dout", dout_o, 0);
    chk("R12 reset ovf", ovf_o, 0);
    chk("R12 reset seen", ovf_seen_o, 0);
  endtask

  task automatic t_passthru;
    for (int m = 0; m < 8; m++) begin
      send(12'hFE3, 1'b1, 3'(m), 3'd2);
      chk("R2 signed fit", dout_o, 6'b100011);
      chk("R1 signed no ovf", ovf_o, 0);
    end
    send(12'h02A, 1'b0, 3'd3, 3'd4);
    chk("R2 unsigned fit", dout_o, 6'b101010);
    chk("R11 valid after sample", valid_o, 1);
    chk("R12 seen still low", ovf_seen_o, 0);
  endtask

  task automatic t_sat;
    send(12'h800, 1'b1, 3'd0, 3'd0);
    chk("R3 neg clamp", dout_o, 6'b100000);
    chk("R1 signed ovf", ovf_o, 1);
    chk("R12 seen rises", ovf_seen_o, 1);
    send(12'h7FF, 1'b1, 3'd0, 3'd0);
    chk("R3 pos clamp", dout_o, 6'b011111);
    send(12'h0A5, 1'b0, 3'd0, 3'd0);
    chk("R3 unsigned clamp", dout_o, 6'b111111);
  endtask

  task automatic t_zero;
    send(12'h800, 1'b1, 3'd1, 3'd0);
    chk("R4 signed zero", dout_o, 0);
    send(12'h0A5, 1'b0, 3'd1, 3'd3);
    chk("R4 unsigned zero", dout_o, 0);
    chk("R1 unsigned ovf", ovf_o, 1);
  endtask

  task automatic t_sym;
    send(12'h800, 1'b1, 3'd2, 3'd0);
    chk("R5 neg sym", dout_o, 6'b100001);
    send(12'h7FF, 1'b1, 3'd2, 3'd0);
    chk("R5 pos sym", dout_o, 6'b011111);
    send(12'h0A5, 1'b0, 3'd2, 3'd0);
    chk("R5 unsigned sym", dout_o, 6'b111111);
  endtask

  task automatic t_wrap;
    send(12'h0A5, 1'b1, 3'd3, 3'd0);
    chk("R6 wrap n0", dout_o, 6'b100101);
    send(12'h0A5, 1'b1, 3'd3, 3'd1);
    chk("R6 wrap n1", dout_o, 6'b000101);
    send(12'h0A5, 1'b1, 3'd3, 3'd3);
    chk("R6 wrap n3", dout_o, 6'b011101);
    send(12'hF45, 1'b1, 3'd3, 3'd2);
    chk("R6 wrap n2 neg", dout_o, 6'b100101);
  endtask

  task automatic t_smwrap;
    send(12'h0A5, 1'b1, 3'd4, 3'd0);
    chk("R7 smwrap n0", dout_o, 6'b011010);
    send(12'h0E5, 1'b1, 3'd4, 3'd0);
    chk("R7 smwrap n0 ld1", dout_o, 6'b100101);
    send(12'h0A5, 1'b1, 3'd4, 3'd1);
    chk("R7 smwrap n1", dout_o, 6'b011010);
    send(12'h0AD, 1'b1, 3'd4, 3'd3);
    chk("R7 smwrap n3", dout_o, 6'b011101);
  endtask

  task automatic t_unsigned_wrap;
    send(12'h0A5, 1'b0, 3'd3, 3'd2);
    chk("R8 unsigned wrap n2", dout_o, 6'b110101);
    send(12'h0A5, 1'b0, 3'd4, 3'd2);
    chk("R8 unsigned smwrap n2", dout_o, 6'b110101);
    send(12'h0A5, 1'b0, 3'd3, 3'd0);
    chk("R8 unsigned wrap n0", dout_o, 6'b100101);
  endtask

  task automatic t_clamp;
    send(12'h0A5, 1'b1, 3'd3, 3'd7);
    chk("R9 clamp n7 signed", dout_o, 6'b011111);
    send(12'h005 | 12'h040, 1'b0, 3'd3, 3'd7);
    chk("R9 clamp n7 unsigned", dout_o, 6'b111111);
  endtask

  task automatic t_badcode;
    send(12'h800, 1'b1, 3'd5, 3'd2);
    chk("R10 code5", dout_o, 6'b100000);
    send(12'h7FF, 1'b1, 3'd7, 3'd2);
    chk("R10 code7", dout_o, 6'b011111);
  endtask

  task automatic t_hold_sticky;
    send(12'h800, 1'b1, 3'd0, 3'd0);
    send(12'h015, 1'b1, 3'd0, 3'd0);
    chk("R1 ovf drops", ovf_o, 0);
    chk("R12 seen held", ovf_seen_o, 1);
    chk("R2 fit after ovf", dout_o, 6'b010101);
    @(negedge clk);
    din_i = 12'h800; mode_i = 3'd1; signed_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 hold dout", dout_o, 6'b010101);
    chk("R11 hold ovf", ovf_o, 0);
    chk("R11 valid low", valid_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; signed_i = 1'b0; mode_i = '0;
    nbits_i = '0; din_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_passthru();
    t_sat();
    t_zero();
    t_sym();
    t_wrap();
    t_smwrap();
    t_unsigned_wrap();
    t_clamp();
    t_badcode();
    t_hold_sticky();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule